// File: doc/BRIEF.md
# Load-Use Stall and Bubble Unit

This block sits in the decode stage of a five-stage in-order pipeline. It works out when the instruction now being decoded reads a register that a load in the execute stage has not yet brought back from memory. Forwarding cannot cover that case, because the value arrives too late, so the pipeline must stall for one cycle.

The block holds the decode/execute control register and the copy of the decoded Rt field that goes with it. It compares the load's Rt against both source fields of the fetch/decode register, using only combinational logic. On a match it drops the write enables for the program counter and the fetch/decode register. As a result, the same instruction is fetched again and the same instruction is decoded again.

In that same cycle it clears every control bit that goes into the decode/execute register, so a no-operation bubble moves on through execute, memory and writeback. The bubble has its memory-read bit cleared. For that reason the re-decoded instruction goes ahead in the next cycle, and the forwarding path from memory/writeback supplies the load's data.

Top module: `load_use_stall`

## Requirements
- R1: While reset is held and in the first cycle after it, `dx_ctrl` and `dx_rt` are zero, `stall` is low, and `pc_we` and `fd_we` are high.
- R2: `stall` is high in the same cycle whenever all three of these hold: bit 3 of `dx_ctrl` (the memory-read bit) is set, `dx_rt` is nonzero, and `dx_rt` equals `fd_rs` or `fd_rt`.
- R3: When `dx_rt` is zero, `stall` stays low even if the memory-read bit is set and a source field matches.
- R4: When bit 3 of `dx_ctrl` is clear, `stall` stays low whatever the other control bits and register fields hold.
- R5: `pc_we` and `fd_we` are both low in a stall cycle and both high in every other cycle.
- R6: After a stall cycle, all nine bits of `dx_ctrl` are zero.
- R7: After a cycle with no stall, `dx_ctrl` equals the `dec_ctrl` value that was presented in that cycle.
- R8: `dx_rt` takes the value of `fd_rt` on every clock edge, whether or not the cycle stalls.
- R9: The block never raises `stall` in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fd_rs | input | 5 | Rs field of the instruction in decode |
| fd_rt | input | 5 | Rt field of the instruction in decode |
| dec_ctrl | input | 9 | Control bits from the decoder; bit 3 is memory-read |
| pc_we | output | 1 | Program counter write enable, active high |
| fd_we | output | 1 | Fetch/decode register write enable, active high |
| stall | output | 1 | Load-use hazard detected this cycle |
| dx_ctrl | output | 9 | Decode/execute control register |
| dx_rt | output | 5 | Decode/execute copy of the Rt field |

## Verification
On every cycle the assertions check the following: the two write enables agree, the bubble clears the whole control word, a clean cycle passes the decoder word through, and no stall happens with register zero, with a non-load, or twice in a row. Some behaviour only shows over a sequence of cycles: a real load followed by a dependent instruction that stalls once and then goes ahead, and a match on Rs alone or on Rt alone. The bench's directed and random scenarios cover these, with a model that follows the register contents.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int CTRL_W    = 9;
  localparam int MEMRD_BIT = 3;

  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
    logic       branch;
    logic       mem_read;
    logic       mem_write;
    logic       reg_write;
    logic       mem_to_reg;
  } ctrl_t;
endpackage

// File: rtl/lu_detect.sv
module lu_detect #(
  parameter int AW = 5
) (
  input  logic          load_in_ex,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  output logic          hazard
);
  logic dst_live;
  logic hit_rs;
  logic hit_rt;

  always_comb begin
    dst_live = (ex_rt != '0);
    hit_rs   = (ex_rt == id_rs);
    hit_rt   = (ex_rt == id_rt);
    hazard   = load_in_ex && dst_live && (hit_rs || hit_rt);
  end
endmodule

// File: rtl/lu_bubble.sv
module lu_bubble
  import lu_pkg::*;
(
  input  logic  kill,
  input  ctrl_t ctrl_in,
  output ctrl_t ctrl_out
);
  always_comb begin
    ctrl_out = kill ? ctrl_t'('0) : ctrl_in;
  end
endmodule

// File: rtl/lu_dx_reg.sv
module lu_dx_reg
  import lu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl_d,
  input  logic [AW-1:0] rt_d,
  output ctrl_t         ctrl_q,
  output logic [AW-1:0] rt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rt_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rt_q   <= rt_d;
    end
  end
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import lu_pkg::*;
#(
  parameter int AW = 5,
  localparam int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fd_rs,
  input  logic [AW-1:0] fd_rt,
  input  logic [CW-1:0] dec_ctrl,
  output logic          pc_we,
  output logic          fd_we,
  output logic          stall,
  output logic [CW-1:0] dx_ctrl,
  output logic [AW-1:0] dx_rt
);
  ctrl_t         ctrl_next;
  ctrl_t         ctrl_now;
  logic          hz;
  logic [AW-1:0] rt_now;

  lu_detect #(.AW(AW)) u_det (
    .load_in_ex (ctrl_now.mem_read),
    .ex_rt      (rt_now),
    .id_rs      (fd_rs),
    .id_rt      (fd_rt),
    .hazard     (hz)
  );

  lu_bubble u_bub (
    .kill     (hz),
    .ctrl_in  (ctrl_t'(dec_ctrl)),
    .ctrl_out (ctrl_next)
  );

  lu_dx_reg #(.AW(AW)) u_dx (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_d (ctrl_next),
    .rt_d   (fd_rt),
    .ctrl_q (ctrl_now),
    .rt_q   (rt_now)
  );

  always_comb begin
    stall   = hz;
    pc_we   = !hz;
    fd_we   = !hz;
    dx_ctrl = ctrl_now;
    dx_rt   = rt_now;
  end
endmodule

// File: rtl/lu_checker.sv
module lu_checker #(
  parameter int AW = 5,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fd_rs,
  input logic [AW-1:0] fd_rt,
  input logic [CW-1:0] dec_ctrl,
  input logic          pc_we,
  input logic          fd_we,
  input logic          stall,
  input logic [CW-1:0] dx_ctrl,
  input logic [AW-1:0] dx_rt
);
  logic unused_ok;
  assign unused_ok = ^{fd_rs, 1'b0};

  // R5: both enables move together and drop only when stalling
  a_r5_we_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == fd_we) && (pc_we != stall));

  // R3: register zero never causes a stall
  a_r3_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_rt == '0) |-> !stall);

  // R4: only a load in execute stalls
  a_r4_nonload: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_ctrl[3] |-> !stall);

  // R6: bubble clears every control bit
  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (dx_ctrl == '0));

  // R7: clean cycle passes decoder control
  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (dx_ctrl == $past(dec_ctrl)));

  // R8: Rt copy always advances
  a_r8_rt_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dx_rt == $past(fd_rt)));

  // R9: single-cycle stall
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
endmodule

bind load_use_stall lu_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fd_rs(fd_rs), .fd_rt(fd_rt),
  .dec_ctrl(dec_ctrl), .pc_we(pc_we), .fd_we(fd_we), .stall(stall),
  .dx_ctrl(dx_ctrl), .dx_rt(dx_rt)
);

// File: tb/sim_load_use_stall.sv
module sim_load_use_stall;
  localparam int AW = 5;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] fd_rs, fd_rt;
  logic [CW-1:0] dec_ctrl;
  logic          pc_we, fd_we, stall;
  logic [CW-1:0] dx_ctrl;
  logic [AW-1:0] dx_rt;

  int n_chk  = 0;
  int n_fail = 0;
  logic [CW-1:0] m_ctrl;
  logic [AW-1:0] m_rt;
  logic          prev_stall;

  always #4 clk = ~clk;

  load_use_stall #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .fd_rs(fd_rs), .fd_rt(fd_rt),
    .dec_ctrl(dec_ctrl), .pc_we(pc_we), .fd_we(fd_we), .stall(stall),
    .dx_ctrl(dx_ctrl), .dx_rt(dx_rt)
  );

  function automatic logic exp_hz(logic [CW-1:0] c, logic [AW-1:0] xr,
                                  logic [AW-1:0] rs, logic [AW-1:0] rt);
    return c[3] && (xr != 0) && ((xr == rs) || (xr == rt));
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, check combinational then registered outputs
  task automatic step(logic [AW-1:0] rs, logic [AW-1:0] rt, logic [CW-1:0] c);
    logic e;
    fd_rs = rs; fd_rt = rt; dec_ctrl = c;
    #1;
    e = exp_hz(m_ctrl, m_rt, rs, rt);
    if (m_ctrl[3] && m_rt == 0) chk("R3 zero dst", {15'd0, stall}, 16'd0);
    else if (!m_ctrl[3])        chk("R4 nonload", {15'd0, stall}, 16'd0);
    else                        chk("R2 detect", {15'd0, stall}, {15'd0, e});
    chk("R5 enables", {14'd0, pc_we, fd_we}, {14'd0, !e, !e});
    if (prev_stall) chk("R9 single", {15'd0, stall}, 16'd0);
    @(posedge clk);
    m_ctrl = e ? '0 : c;
    m_rt = rt;
    prev_stall = e;
    @(negedge clk);
    if (e) chk("R6 bubble", {7'd0, dx_ctrl}, 16'd0);
    else   chk("R7 pass", {7'd0, dx_ctrl}, {7'd0, m_ctrl});
    chk("R8 rt copy", {11'd0, dx_rt}, {11'd0, m_rt});
  endtask

  localparam logic [CW-1:0] LW  = 9'b0_00_1_0_1_0_1_1;
  localparam logic [CW-1:0] ALU = 9'b1_10_0_0_0_0_1_0;

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; fd_rs = '0; fd_rt = '0; dec_ctrl = '1;
    m_ctrl = '0; m_rt = '0; prev_stall = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", {7'd0, dx_ctrl}, 16'd0);
    chk("R1 reset rt", {11'd0, dx_rt}, 16'd0);
    chk("R1 reset we", {13'd0, pc_we, fd_we, stall}, 16'd6);
    rst_n = 1'b1;
    dec_ctrl = '0;
    // directed: load to r2, dependent on Rs
    step(5'd1, 5'd2, LW);
    step(5'd2, 5'd7, ALU);   // stall expected
    step(5'd2, 5'd7, ALU);   // re-decoded, must go ahead
    // dependent on Rt only
    step(5'd3, 5'd9, LW);
    step(5'd4, 5'd9, ALU);
    step(5'd4, 5'd9, ALU);
    // load with Rt = 0
    step(5'd0, 5'd0, LW);
    step(5'd0, 5'd0, ALU);
    // non-load producer with matching fields
    step(5'd6, 5'd6, ALU);
    step(5'd6, 5'd6, ALU);
    // load followed by load on same register
    step(5'd1, 5'd5, LW);
    step(5'd5, 5'd5, LW);
    step(5'd5, 5'd5, LW);
    step(5'd8, 5'd8, ALU);
    // random
    for (int i = 0; i < 2000; i++) begin
      logic [CW-1:0] c;
      c = 9'($urandom);
      if ($urandom % 2 == 0) c[3] = 1'b1;
      step(5'($urandom % 4), 5'($urandom % 4), c);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule